// File: doc/BRIEF.md
# Lane-Parallel Carry-Less Multiplier

This block multiplies 64-bit words as polynomials over GF(2), so partial products are combined with XOR and no carries propagate. Each operand vector is split into independent 128-bit lanes of two 64-bit words. The lane count is a parameter: 1, 2 or 4 lanes, which gives operands of 2, 4 or 8 words. An 8-bit selector byte picks the low or high word of each operand. The same choice applies to every lane. Each lane's full 128-bit product replaces that lane of the result.

A request is issued by pulsing `start` while the block is idle. The operands and the two relevant selector bits are registered at that edge. A small controller then steps through three named states. In `ST_IDLE` the block waits. When `start` arrives, transition `T_ACCEPT` moves it to `ST_CALC`. In `ST_CALC` the lane products settle through combinational XOR-shift arrays, and transition `T_LOAD` writes them into the result register and moves to `ST_FINISH`. In `ST_FINISH` `done` is high for one cycle, and transition `T_RELEASE` returns to `ST_IDLE`. The latency does not depend on the lane count, because all lanes are evaluated in parallel.

Top module: `clmul_lanes`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every bit of `result` is 0.
- R2: Selector bit 0 picks the first-operand word in each lane i. A value of 0 takes word 2i (bits [128i+63:128i]) and a value of 1 takes word 2i+1 (bits [128i+127:128i+64]).
- R3: Selector bit 4 makes the same low/high choice for the second operand, independently of bit 0.
- R4: Selector bits 1, 2, 3, 5, 6 and 7 have no effect on the result.
- R5: Each lane product is the XOR, over every set bit k of the selected second word, of the selected first word shifted left by k. The product is 128 bits wide and its bit 127 is always 0.
- R6: The product of lane i is written to `result[128i+127:128i]`, with its low 64 bits in the lower word. Different lanes use their own words.
- R7: An accepted `start` is followed two clock edges later by `done` high for exactly one cycle, with the new `result` valid at that time. `result` then holds until the next accepted request. `busy` is high from the edge after acceptance until `done` falls.
- R8: A `start` that arrives while `busy` is high is ignored. It captures no operands and causes no extra `done`.
- R9: Known-answer vectors. Squaring 0x8000000000000000 with selector 0x00 gives a product of {hi 0x4000000000000000, lo 0}. The first operand is {hi 0x7b5b546573745665, lo 0x63746f725d53475d} and the second is {hi 0x4869285368617929, lo 0x5b477565726f6e5d}. With these, selector 0x00 gives {0x1d4d84c85c3440c0, 0x929633d5d36f0451}, 0x11 gives {0x1d1e1f2c592e7c45, 0xd66ee03e410fd4ed}, 0x10 gives {0x1bd17c8d556ab5a1, 0x7fa540ac2a281315`}, and 0x01 gives {0x1a2bf6db3a30862f, 0xbabf262df4b7d5c9}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| sel_byte | input | 8 | Word selector; only bits 0 and 4 are used |
| opnd_a | input | LANES*128 | First operand vector |
| opnd_b | input | LANES*128 | Second operand vector |
| busy | output | 1 | A request is in flight |
| done | output | 1 | One-cycle completion pulse |
| result | output | LANES*128 | Lane products |

## Verification
The hardest case to reach is a request that arrives while the block is busy. It only matters if it carries different operands and a different selector from the request in flight. The bench therefore holds `start` high into the cycle after acceptance and swaps in fresh operands at that moment. It then checks that the completed result still belongs to the first request and that only one `done` pulse appears. A reference model that tracks phases runs beside the design and is compared on every clock. Lane independence is exercised with different random words in each lane and selector bytes with junk in the unused bits.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
    localparam int WORD_W = 64;
    localparam int LANE_W = 2 * WORD_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_FINISH = 2'd2
    } clmul_state_e;
endpackage

// File: rtl/clmul_ctrl.sv
module clmul_ctrl
    import clmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic cap_en,
    output logic load_en,
    output logic busy,
    output logic done
);
    clmul_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CALC;   // T_ACCEPT
            ST_CALC:   state_d = ST_FINISH;            // T_LOAD
            ST_FINISH: state_d = ST_IDLE;              // T_RELEASE
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        cap_en  = (state_q == ST_IDLE) && start;
        load_en = (state_q == ST_CALC);
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_FINISH);
    end

    // R7: completion is a single-cycle pulse
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: an accepted request makes the block busy
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));
    // R8: a busy block releases only through done
    p_busy_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: rtl/clmul_word_sel.sv
module clmul_word_sel
    import clmul_pkg::*;
(
    input  logic [LANE_W-1:0] lane_in,
    input  logic              pick_hi,
    output logic [WORD_W-1:0] word_out
);
    always_comb begin
        word_out = pick_hi ? lane_in[LANE_W-1:WORD_W] : lane_in[WORD_W-1:0];
    end
endmodule

// File: rtl/clmul_core.sv
module clmul_core
    import clmul_pkg::*;
(
    input  logic [WORD_W-1:0] mcand,
    input  logic [WORD_W-1:0] mplier,
    output logic [LANE_W-1:0] product
);
    always_comb begin
        product = '0;
        for (int k = 0; k < WORD_W; k++) begin
            if (mplier[k]) product = product ^ ({{WORD_W{1'b0}}, mcand} << k);
        end
    end
endmodule

// File: rtl/clmul_lanes.sv
module clmul_lanes
    import clmul_pkg::*;
#(
    parameter int LANES = 4,
    localparam int VEC_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       sel_byte,
    input  logic [VEC_W-1:0] opnd_a,
    input  logic [VEC_W-1:0] opnd_b,
    output logic             busy,
    output logic             done,
    output logic [VEC_W-1:0] result
);
    logic             cap_en, load_en;
    logic [VEC_W-1:0] a_q, b_q, prod_vec, result_q;
    logic             hi_a_q, hi_b_q;

    clmul_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cap_en  (cap_en),
        .load_en (load_en),
        .busy    (busy),
        .done    (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q    <= '0;
            b_q    <= '0;
            hi_a_q <= 1'b0;
            hi_b_q <= 1'b0;
        end else if (cap_en) begin
            a_q    <= opnd_a;
            b_q    <= opnd_b;
            hi_a_q <= sel_byte[0];
            hi_b_q <= sel_byte[4];
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [WORD_W-1:0] wa, wb;
        clmul_word_sel u_sel_a (
            .lane_in  (a_q[i*LANE_W +: LANE_W]),
            .pick_hi  (hi_a_q),
            .word_out (wa)
        );
        clmul_word_sel u_sel_b (
            .lane_in  (b_q[i*LANE_W +: LANE_W]),
            .pick_hi  (hi_b_q),
            .word_out (wb)
        );
        clmul_core u_core (
            .mcand   (wa),
            .mplier  (wb),
            .product (prod_vec[i*LANE_W +: LANE_W])
        );

        // R5: the top product bit of every lane stays clear
        p_top_bit_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !result_q[i*LANE_W + LANE_W - 1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       result_q <= '0;
        else if (load_en) result_q <= prod_vec;
    end

    assign result = result_q;

    // R8: captured operands do not move while a request is in flight
    p_hold_operands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_q) && $stable(b_q) && $stable(hi_a_q) && $stable(hi_b_q)));
    // R7: result changes only on the load edge, which precedes done
    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_q) |-> done);
endmodule

// File: tb/clmul_lanes_tb.sv
`timescale 1ns/1ps
module clmul_lanes_tb;
    localparam int LANES = 4;
    localparam int VW = LANES * 128;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic [7:0] sel_byte = 0;
    logic [VW-1:0] opnd_a = '0, opnd_b = '0;
    logic busy, done;
    logic [VW-1:0] result;

    int checks = 0, failures = 0;

    always #2.5 clk = ~clk;

    clmul_lanes #(.LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_byte(sel_byte),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done), .result(result)
    );

    function automatic logic [127:0] poly_mul(logic [63:0] x, logic [63:0] y);
        logic [127:0] acc = '0;
        for (int j = 0; j < 64; j++)
            if (x[j]) acc ^= ({64'd0, y} << j);
        return acc;
    endfunction

    function automatic logic [VW-1:0] expect_vec(logic [VW-1:0] a, logic [VW-1:0] b, logic [7:0] s);
        logic [VW-1:0] r = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [63:0] x = s[0] ? a[i*128+64 +: 64] : a[i*128 +: 64];
            logic [63:0] y = s[4] ? b[i*128+64 +: 64] : b[i*128 +: 64];
            r[i*128 +: 128] = poly_mul(x, y);
        end
        return r;
    endfunction

    // Behavioural reference: phase counter plus saved request
    int phase = 0;
    logic [VW-1:0] m_a, m_b, m_res = '0;
    logic [7:0] m_s;
    always @(posedge clk) begin
        if (!rst_n) begin
            phase = 0; m_res = '0;
        end else begin
            case (phase)
                0: if (start) begin phase = 1; m_a = opnd_a; m_b = opnd_b; m_s = sel_byte; end
                1: begin phase = 2; m_res = expect_vec(m_a, m_b, m_s); end
                default: phase = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (done !== (phase == 2) || busy !== (phase != 0)) begin
                failures++;
                $display("FAIL R7 done/busy actual=%b/%b expected=%b/%b", done, busy, phase == 2, phase != 0);
            end
            checks++;
            if (result !== m_res) begin
                failures++;
                $display("FAIL R5 result actual=%h expected=%h", result, m_res);
            end
        end
    end

    task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [VW-1:0] a, logic [VW-1:0] b, logic [7:0] s);
        @(negedge clk);
        opnd_a = a; opnd_b = b; sel_byte = s; start = 1;
        @(negedge clk);
        start = 0;
        @(negedge clk);
    endtask

    function automatic logic [VW-1:0] bcast(logic [127:0] v);
        return {LANES{v}};
    endfunction

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        logic [127:0] ka = {64'h7b5b546573745665, 64'h63746f725d53475d};
        logic [127:0] kb = {64'h4869285368617929, 64'h5b477565726f6e5d};
        logic [VW-1:0] ra, rb, r1;
        repeat (3) @(negedge clk);
        chk("R1 reset result", result, '0);
        chk("R1 reset busy/done", {{(VW-2){1'b0}}, busy, done}, '0);
        rst_n = 1;

        run_op(bcast({64'd0, 64'h8000000000000000}), bcast({64'd0, 64'h8000000000000000}), 8'h00);
        chk("R9 square top bit", result, bcast({64'h4000000000000000, 64'd0}));
        chk("R7 done pulse", {{(VW-1){1'b0}}, done}, 1);
        run_op(bcast(ka), bcast(kb), 8'h00);
        chk("R9 kat sel00", result, bcast({64'h1d4d84c85c3440c0, 64'h929633d5d36f0451}));
        run_op(bcast(ka), bcast(kb), 8'h11);
        chk("R9 kat sel11", result, bcast({64'h1d1e1f2c592e7c45, 64'hd66ee03e410fd4ed}));
        run_op(bcast(ka), bcast(kb), 8'h10);
        chk("R3 R9 kat sel10", result, bcast({64'h1bd17c8d556ab5a1, 64'h7fa540ac2a281315}));
        run_op(bcast(ka), bcast(kb), 8'h01);
        chk("R2 R9 kat sel01", result, bcast({64'h1a2bf6db3a30862f, 64'hbabf262df4b7d5c9}));
        @(negedge clk);
        chk("R7 result holds", result, bcast({64'h1a2bf6db3a30862f, 64'hbabf262df4b7d5c9}));

        for (int t = 0; t < 24; t++) begin
            logic [7:0] s = 8'($urandom);
            ra = rnd_vec(); rb = rnd_vec();
            run_op(ra, rb, s);
            chk("R6 per-lane random", result, expect_vec(ra, rb, s));
            chk("R4 unused bits", result, expect_vec(ra, rb, s & 8'h11));
        end

        ra = rnd_vec(); rb = rnd_vec();
        run_op(ra, rb, 8'hEE);
        chk("R4 sel EE as 00", result, expect_vec(ra, rb, 8'h00));

        // R8: start held while busy with other data
        ra = rnd_vec(); rb = rnd_vec();
        r1 = expect_vec(ra, rb, 8'h10);
        @(negedge clk);
        opnd_a = ra; opnd_b = rb; sel_byte = 8'h10; start = 1;
        @(negedge clk);
        opnd_a = rnd_vec(); opnd_b = rnd_vec(); sel_byte = 8'h01;
        @(negedge clk);
        start = 0;
        chk("R8 busy start ignored", result, r1);
        @(negedge clk);
        chk("R8 no extra done", {{(VW-1){1'b0}}, done}, 0);
        chk("R8 result kept", result, r1);
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule